// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block keeps the interrupt bookkeeping of a serial port. Single-cycle pulses from the receive, transmit, timeout, modem-status and error logic each set one bit of an eleven-bit raw status register. Software can enable any subset of these bits through a mask register. It can read the raw status, the mask and the masked status (raw AND mask) back. It acknowledges interrupts by writing ones to a clear address.

Six registered interrupt lines come out of the masked status. One combined line goes high whenever any masked bit is set. Three lines each follow a single source: receive, transmit and timeout. Two lines each gather a group of four bits: the modem group and the error group. A write of a byte to the transmit-data address also raises the transmit bit, so a driver gets a transmit interrupt after each byte it queues.

Register word addresses are 0 for transmit data (write), 1 for the mask (read/write), 2 for the raw status (read), 3 for the masked status (read) and 4 for the clear address (write). Reads return the value zero-extended to 32 bits. Unused addresses read zero.

Top module: `uart_irq_agg`

## Requirements
- R1: While reset is asserted, and after it is released, the raw status, the mask, the masked status and all six lines are zero.
- R2: A pulse on bit i of `src_evt` sets raw status bit i at the next clock edge. The bit positions are: ring 0, clear-to-send 1, carrier 2, data-set-ready 3, receive 4, transmit 5, timeout 6, framing 7, parity 8, break 9, overrun 10. A set bit stays set until it is cleared.
- R3: A read of address 3 returns the raw status ANDed with the mask. A read of address 2 returns the raw status.
- R4: `irq_any` is the OR of all eleven masked bits.
- R5: `irq_rx`, `irq_tx` and `irq_tmo` follow masked bits 4, 5 and 6 respectively.
- R6: `irq_modem` is the OR of masked bits 0 to 3. `irq_err` is the OR of masked bits 7 to 10.
- R7: A write to address 4 clears each raw bit whose written value is 1. Bits written as 0 keep their value.
- R8: A write to address 1 loads the mask from `reg_wdata[10:0]`, and the lines reflect the new mask one cycle after the write. Address 1 reads the mask back, and bits 31 to 11 read as zero.
- R9: A write to address 0 sets raw bit 5 (transmit), whatever the data value.
- R10: If a bit gets a set pulse and a clear write in the same cycle, the bit ends up set.
- R11: A write to address 2 or address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 11 | One-cycle set pulses, one per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_any | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_tmo | output | 1 | Receive timeout interrupt line |
| irq_modem | output | 1 | Modem-status group line |
| irq_err | output | 1 | Error group line |

## Verification
Each stimulus is an event pulse, a register write, or both. The block takes it in at a rising edge. Both the register state and the six lines hold the result right after that same edge, so each result is due one cycle after its stimulus. Reads are combinational from the register state, so a read issued in the following low phase returns the new value. The bench drives each stimulus at a falling edge and removes it at the next falling edge. It then samples the lines and reads back the registers while the clock is low, half a period after the edge that took the stimulus in.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_SRC = 11;
  localparam int unsigned NUM_LN  = 6;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 3;

  localparam int unsigned B_RING = 0;
  localparam int unsigned B_CTS  = 1;
  localparam int unsigned B_DCD  = 2;
  localparam int unsigned B_DSR  = 3;
  localparam int unsigned B_RX   = 4;
  localparam int unsigned B_TX   = 5;
  localparam int unsigned B_TMO  = 6;
  localparam int unsigned B_FRM  = 7;
  localparam int unsigned B_PAR  = 8;
  localparam int unsigned B_BRK  = 9;
  localparam int unsigned B_OVR  = 10;

  localparam logic [ADDR_W-1:0] A_TXDATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RAW    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSKD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd4;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Which status bits feed line ln (0 any, 1 rx, 2 tx, 3 timeout, 4 modem, 5 error)
  function automatic src_vec_t line_sel(input int unsigned ln);
    src_vec_t m;
    m = '0;
    case (ln)
      0: m = '1;
      1: m[B_RX] = 1'b1;
      2: m[B_TX] = 1'b1;
      3: m[B_TMO] = 1'b1;
      4: begin
        m[B_RING] = 1'b1; m[B_CTS] = 1'b1; m[B_DCD] = 1'b1; m[B_DSR] = 1'b1;
      end
      5: begin
        m[B_FRM] = 1'b1; m[B_PAR] = 1'b1; m[B_BRK] = 1'b1; m[B_OVR] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  // Next raw state: sets dominate clears
  function automatic src_vec_t next_raw(input src_vec_t cur, input src_vec_t set,
                                        input src_vec_t clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import uart_irq_pkg::*;
(
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  src_vec_t          raw_q,
  input  src_vec_t          mask_q,
  output logic              tx_wr,
  output logic              mask_we,
  output src_vec_t          mask_wdata,
  output src_vec_t          clr_vec,
  output logic [DATA_W-1:0] reg_rdata
);
  logic unused_wdata_hi;

  assign tx_wr      = reg_wr && (reg_addr == A_TXDATA);
  assign mask_we    = reg_wr && (reg_addr == A_MASK);
  assign mask_wdata = reg_wdata[NUM_SRC-1:0];
  assign clr_vec    = (reg_wr && (reg_addr == A_CLEAR)) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = DATA_W'(mask_q);
      A_RAW:   reg_rdata = DATA_W'(raw_q);
      A_MSKD:  reg_rdata = DATA_W'(raw_q & mask_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  src_vec_t clr_vec,
  input  logic     mask_we,
  input  src_vec_t mask_wdata,
  output src_vec_t raw_q,
  output src_vec_t mask_q,
  output src_vec_t raw_d,
  output src_vec_t mask_d
);
  assign raw_d  = next_raw(raw_q, set_vec, clr_vec);
  assign mask_d = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/irq_line_fold.sv
module irq_line_fold
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  src_vec_t          raw_d,
  input  src_vec_t          mask_d,
  output logic [NUM_LN-1:0] line_q
);
  src_vec_t          mskd_d;
  logic [NUM_LN-1:0] line_d;

  assign mskd_d = raw_d & mask_d;

  for (genvar g = 0; g < NUM_LN; g++) begin : g_line
    assign line_d[g] = |(mskd_d & line_sel(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [10:0]       src_evt,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_any,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_tmo,
  output logic              irq_modem,
  output logic              irq_err
);
  src_vec_t          raw_q, mask_q, raw_d, mask_d;
  src_vec_t          set_vec, clr_vec, mask_wdata;
  logic              tx_wr, mask_we;
  logic [NUM_LN-1:0] line_q;

  irq_reg_decode u_dec (
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .raw_q      (raw_q),
    .mask_q     (mask_q),
    .tx_wr      (tx_wr),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .clr_vec    (clr_vec),
    .reg_rdata  (reg_rdata)
  );

  // Event pulses plus the transmit bit raised by a data write
  assign set_vec = src_evt | (src_vec_t'(tx_wr) << B_TX);

  irq_status_reg u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .raw_q      (raw_q),
    .mask_q     (mask_q),
    .raw_d      (raw_d),
    .mask_d     (mask_d)
  );

  irq_line_fold u_fold (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_d  (raw_d),
    .mask_d (mask_d),
    .line_q (line_q)
  );

  assign irq_any   = line_q[0];
  assign irq_rx    = line_q[1];
  assign irq_tx    = line_q[2];
  assign irq_tmo   = line_q[3];
  assign irq_modem = line_q[4];
  assign irq_err   = line_q[5];
endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk
  import uart_irq_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input src_vec_t raw_q,
  input src_vec_t mask_q,
  input src_vec_t set_vec,
  input src_vec_t clr_vec,
  input logic     irq_any,
  input logic     irq_rx,
  input logic     irq_tx,
  input logic     irq_tmo,
  input logic     irq_modem,
  input logic     irq_err
);
  src_vec_t mskd;
  assign mskd = raw_q & mask_q;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (raw_q == '0 && mask_q == '0));

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  a_r4_any_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (mskd != '0));

  a_r5_single_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx == mskd[B_RX]) && (irq_tx == mskd[B_TX]) && (irq_tmo == mskd[B_TMO]));

  a_r6_group_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_modem == (mskd[3:0] != '0)) && (irq_err == (mskd[10:7] != '0)));

  a_r7_clear_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> ((raw_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));
endmodule

bind uart_irq_agg uart_irq_agg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .raw_q     (raw_q),
  .mask_q    (mask_q),
  .set_vec   (set_vec),
  .clr_vec   (clr_vec),
  .irq_any   (irq_any),
  .irq_rx    (irq_rx),
  .irq_tx    (irq_tx),
  .irq_tmo   (irq_tmo),
  .irq_modem (irq_modem),
  .irq_err   (irq_err)
);

// File: tb/uart_irq_agg_tb.sv
module uart_irq_agg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [10:0] ev;
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] wd;
    logic [10:0] exp_raw;
    logic [5:0]  exp_ln;   // {any, rx, tx, tmo, modem, err}
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{11'h000, 1'b1, 3'd1, 32'h0000_07FF, 11'h000, 6'h00},  // R8 enable all
    '{11'h010, 1'b0, 3'd0, 32'h0,         11'h010, 6'h30},  // R2 R5 rx
    '{11'h001, 1'b0, 3'd0, 32'h0,         11'h011, 6'h32},  // R6 modem
    '{11'h100, 1'b0, 3'd0, 32'h0,         11'h111, 6'h33},  // R6 error
    '{11'h000, 1'b1, 3'd4, 32'h0000_0011, 11'h100, 6'h21},  // R7 w1c
    '{11'h000, 1'b1, 3'd0, 32'h0000_0041, 11'h120, 6'h29},  // R9 tx data
    '{11'h000, 1'b1, 3'd1, 32'h0000_0020, 11'h120, 6'h28},  // R8 mask to tx
    '{11'h040, 1'b0, 3'd0, 32'h0,         11'h160, 6'h28},  // R3 masked off
    '{11'h000, 1'b1, 3'd1, 32'h0000_0040, 11'h160, 6'h24},  // R5 tmo
    '{11'h400, 1'b1, 3'd4, 32'h0000_07FF, 11'h400, 6'h00},  // R10 set wins
    '{11'h000, 1'b1, 3'd1, 32'hFFFF_FFFF, 11'h400, 6'h21},  // R4 R8
    '{11'h00A, 1'b0, 3'd0, 32'h0,         11'h40A, 6'h23}   // R2 R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] src_evt = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_any, irq_rx, irq_tx, irq_tmo, irq_modem, irq_err;

  int n_chk = 0;
  int n_err = 0;
  logic [10:0] mask_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_tmo(irq_tmo),
    .irq_modem(irq_modem), .irq_err(irq_err)
  );

  function automatic logic [5:0] lines_now();
    return {irq_any, irq_rx, irq_tx, irq_tmo, irq_modem, irq_err};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Drive for one cycle starting at a falling edge, idle at the next falling edge
  task automatic apply(input logic [10:0] ev, input logic wr, input logic [2:0] a,
                       input logic [31:0] wd);
    src_evt = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    src_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 lines in reset", 32'(lines_now()), 32'h0);
    rd(3'd2, d); check("R1 raw in reset", d, 32'h0);
    rd(3'd1, d); check("R1 mask in reset", d, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd3, d); check("R1 masked after reset", d, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].ev, VEC[i].wr, VEC[i].addr, VEC[i].wd);
      if (VEC[i].wr && VEC[i].addr == 3'd1) mask_m = VEC[i].wd[10:0];
      check($sformatf("R4 R5 R6 lines vec %0d", i), 32'(lines_now()), 32'(VEC[i].exp_ln));
      rd(3'd2, d); check($sformatf("R2 R7 R9 R10 raw vec %0d", i), d, 32'(VEC[i].exp_raw));
      rd(3'd3, d); check($sformatf("R3 masked vec %0d", i), d, 32'(VEC[i].exp_raw & mask_m));
    end

    // R8: mask readback, upper bits zero after all-ones write
    rd(3'd1, d); check("R8 mask readback", d, 32'h0000_07FF);

    // R11: writes to raw and masked addresses change nothing
    apply(11'h000, 1'b1, 3'd2, 32'h0000_07FF);
    rd(3'd2, d); check("R11 raw after raw write", d, 32'h0000_040A);
    apply(11'h000, 1'b1, 3'd3, 32'h0000_0000);
    rd(3'd3, d); check("R11 masked after masked write", d, 32'h0000_040A);
    rd(3'd1, d); check("R11 mask intact", d, 32'h0000_07FF);
    check("R11 lines intact", 32'(lines_now()), 32'h23);

    // R7: clear with zeros leaves all bits alone
    apply(11'h000, 1'b1, 3'd4, 32'h0000_0000);
    rd(3'd2, d); check("R7 zero clear no effect", d, 32'h0000_040A);

    // R9: tx bit via data write with mask off still sets raw
    apply(11'h000, 1'b1, 3'd1, 32'h0);
    check("R8 mask zero drops lines", 32'(lines_now()), 32'h00);
    apply(11'h000, 1'b1, 3'd0, 32'h0000_0000);
    rd(3'd2, d); check("R9 tx set by data write", d, 32'h0000_042A);
    check("R9 lines stay low while masked", 32'(lines_now()), 32'h00);

    // R1: reset mid-run
    apply(11'h000, 1'b1, 3'd1, 32'h0000_07FF);
    check("R4 any after mask", 32'(irq_any), 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 lines after mid reset", 32'(lines_now()), 32'h0);
    rd(3'd2, d); check("R1 raw after mid reset", d, 32'h0);
    rd(3'd1, d); check("R1 mask after mid reset", d, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule